// File: doc/BRIEF.md
# Flash Self-Programming Mode Control Register

This block is an 8-bit control and status register that sits on a simple memory-mapped bus at one address. It controls when the on-chip flash may enter its self-programming mode, where a program running from RAM issues program and erase commands. Software reads the register to see whether the flash engine is ready or busy and whether the mode is active. It writes the register to request the mode, to reset the flash control circuit, and to choose between the user area and the boot area.

Two control bits are protected against a stray write. Each one sets only when a write that carries 0 in that bit is followed by the next write to the register carrying 1 in that bit. A write that carries 0 always clears the bit. The mode becomes active only while the programming voltage is present. The control-circuit reset has effect only while the mode is selected. While the chip is in boot mode, the boot area is always selected.

Top module: `flash_rewrite_ctl`

## Requirements
- R1: After reset, with the engine idle and boot mode low, the register reads 0x01 and rewriteEn, ctlReset and bootAreaSel are all 0.
- R2: Bit 0 reads 0 while engineBusy is 1 and reads 1 otherwise.
- R3: Bit 1 (mode select) becomes 1 only on a write with bit 1 = 1 whose previous write to the register had bit 1 = 0. Cycles without a write do not cancel the pending arm. Any write with bit 1 = 0 clears the bit.
- R4: A write with bit 1 = 1 or bit 3 = 1 that is not armed leaves that bit unchanged. Because the arm state is clear after reset, the first write after reset cannot set either bit.
- R5: Bit 2 and rewriteEn both equal bit 1 AND progVoltOk, and they follow progVoltOk within the same cycle.
- R6: Bit 3 (control reset) uses the same arming rule as bit 1, but its arm state is tracked separately. A write with bit 3 = 0 clears bit 3.
- R7: ctlReset is 1 only while both bit 3 and bit 1 are 1. Bit 3 can hold 1 while bit 1 is 0, and it still reads back as 1.
- R8: Bit 4 (area select) takes the written value on every write with no arming. bootAreaSel and the read value of bit 4 equal the stored bit OR bootMode.
- R9: Write data in bits 0, 2 and 7..5 has no effect. Bits 7..5 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 1 | The bus access targets this register |
| wrEn | input | 1 | Write strobe, qualified by regSel |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Register read value (combinational) |
| progVoltOk | input | 1 | Programming voltage is present on the dedicated pin |
| bootMode | input | 1 | Chip is running in boot mode |
| engineBusy | input | 1 | Flash engine is programming or erasing |
| rewriteEn | output | 1 | Self-programming mode is active |
| ctlReset | output | 1 | Reset to the flash control circuit |
| bootAreaSel | output | 1 | 1 selects the boot area, 0 the user area |

## Verification
The arm state cannot be read directly, so an error in it shows up on the next write that carries a 1 in a protected bit. Too eager an arm lets a lone 1 write set bit 1 or bit 3 right after reset. A lost arm stops the 0-then-1 sequence from taking effect. Either fault is visible on rdData and rewriteEn one cycle after that write. Sharing one arm flag between the two protected bits is exposed by a sequence in which bit 3 is armed while bit 1 is not, which shows up in the same cycle on ctlReset and on bit 3 of the read value.

// File: rtl/flash_rw_pkg.sv
package flash_rw_pkg;
  localparam int REG_W   = 8;
  localparam int READY_B = 0;
  localparam int SEL_B   = 1;
  localparam int ENTRY_B = 2;
  localparam int RST_B   = 3;
  localparam int AREA_B  = 4;
  localparam int PROT_N  = 2;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic setSel;
    logic clrSel;
    logic setRst;
    logic clrRst;
    logic loadArea;
    logic areaVal;
  } frStrobe_t;

  function automatic int protBit(input int idx);
    return (idx == 0) ? SEL_B : RST_B;
  endfunction
endpackage

// File: rtl/flash_rw_ctrl.sv
module flash_rw_ctrl
  import flash_rw_pkg::*;
#(
  parameter int DATA_W = REG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [DATA_W-1:0] wrData,
  output frStrobe_t         strobes
);
  logic [PROT_N-1:0] armQ;
  logic [PROT_N-1:0] setP;
  logic [PROT_N-1:0] clrP;

  // One arm flag for each protected bit. The flag records whether the most
  // recent write carried 0 in that bit.
  for (genvar g = 0; g < PROT_N; g++) begin : g_prot
    localparam int B = protBit(g);
    always_ff @(posedge clk) begin
      if (!rstN)      armQ[g] <= 1'b0;
      else if (wrStb) armQ[g] <= ~wrData[B];
    end
    assign setP[g] = wrStb &  wrData[B] & armQ[g];
    assign clrP[g] = wrStb & ~wrData[B];
  end

  always_comb begin
    strobes.setSel   = setP[0];
    strobes.clrSel   = clrP[0];
    strobes.setRst   = setP[1];
    strobes.clrRst   = clrP[1];
    strobes.loadArea = wrStb;
    strobes.areaVal  = wrData[AREA_B];
  end

  // R3: a set never follows a write that was itself a set of the same bit
  a_r3_no_back_to_back_set: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setSel |=> !strobes.setSel);
  // R6: the reset bit cannot be set twice in a row without a 0 write between
  a_r6_no_back_to_back_set: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setRst |=> !strobes.setRst);
endmodule

// File: rtl/flash_rw_dp.sv
module flash_rw_dp
  import flash_rw_pkg::*;
#(
  parameter int DATA_W = REG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  frStrobe_t         strobes,
  input  logic              progVoltOk,
  input  logic              bootMode,
  input  logic              engineBusy,
  output logic [DATA_W-1:0] rdData,
  output logic              selBit,
  output logic              rewriteEn,
  output logic              ctlReset,
  output logic              bootAreaSel
);
  logic selQ, rstQ, areaQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ  <= 1'b0;
      rstQ  <= 1'b0;
      areaQ <= 1'b0;
    end else begin
      if (strobes.clrSel)      selQ <= 1'b0;
      else if (strobes.setSel) selQ <= 1'b1;
      if (strobes.clrRst)      rstQ <= 1'b0;
      else if (strobes.setRst) rstQ <= 1'b1;
      if (strobes.loadArea)    areaQ <= strobes.areaVal;
    end
  end

  assign selBit      = selQ;
  assign rewriteEn   = selQ & progVoltOk;
  assign ctlReset    = rstQ & selQ;
  assign bootAreaSel = areaQ | bootMode;

  always_comb begin
    rdData          = '0;
    rdData[READY_B] = ~engineBusy;
    rdData[SEL_B]   = selQ;
    rdData[ENTRY_B] = rewriteEn;
    rdData[RST_B]   = rstQ;
    rdData[AREA_B]  = bootAreaSel;
  end

  // R6: a clear strobe releases the reset bit on the next cycle
  a_r6_release: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrRst |=> !rstQ);
  // R3: a set strobe without a clear leaves the select bit at 1
  a_r3_set_takes: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.setSel && !strobes.clrSel) |=> selQ);
  // R8: the area bit follows each write
  a_r8_area_load: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadArea |=> (areaQ == $past(strobes.areaVal)));
endmodule

// File: rtl/flash_rewrite_ctl.sv
module flash_rewrite_ctl
  import flash_rw_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regSel,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             progVoltOk,
  input  logic             bootMode,
  input  logic             engineBusy,
  output logic             rewriteEn,
  output logic             ctlReset,
  output logic             bootAreaSel
);
  logic      wrStb;
  logic      selBit;
  frStrobe_t strobes;

  assign wrStb = regSel & wrEn;

  flash_rw_ctrl #(.DATA_W(REG_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrStb  (wrStb),
    .wrData (wrData),
    .strobes(strobes)
  );

  flash_rw_dp #(.DATA_W(REG_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .progVoltOk (progVoltOk),
    .bootMode   (bootMode),
    .engineBusy (engineBusy),
    .rdData     (rdData),
    .selBit     (selBit),
    .rewriteEn  (rewriteEn),
    .ctlReset   (ctlReset),
    .bootAreaSel(bootAreaSel)
  );

  // R3: a write with bit 1 = 0 clears the select bit
  a_r3_zero_clears: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && !wrData[SEL_B]) |=> !rdData[SEL_B]);
  // R3: the select bit rises only after a write with bit 1 = 1
  a_r3_rise_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selBit) |-> $past(wrStb && wrData[SEL_B]));
  // R5: the mode is active only with the programming voltage present
  a_r5_needs_volt: assert property (@(posedge clk) disable iff (!rstN)
    rewriteEn |-> (progVoltOk && selBit));
  // R7: the control reset takes effect only while the mode is selected
  a_r7_gated: assert property (@(posedge clk) disable iff (!rstN)
    ctlReset |-> selBit);
  // R8: boot mode forces the boot area
  a_r8_boot_forces: assert property (@(posedge clk) disable iff (!rstN)
    bootMode |-> bootAreaSel);
  // R2: the ready flag mirrors the engine
  a_r2_ready: assert property (@(posedge clk) disable iff (!rstN)
    rdData[READY_B] != engineBusy);
endmodule

// File: tb/flash_rewrite_ctl_test.sv
module flash_rewrite_ctl_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regSel = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       progVoltOk = 1'b0;
  logic       bootMode = 1'b0;
  logic       engineBusy = 1'b0;
  logic       rewriteEn, ctlReset, bootAreaSel;
  int         checks = 0;
  int         errors = 0;

  always #5 clk = ~clk;

  flash_rewrite_ctl uut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .progVoltOk(progVoltOk), .bootMode(bootMode),
    .engineBusy(engineBusy), .rewriteEn(rewriteEn), .ctlReset(ctlReset),
    .bootAreaSel(bootAreaSel)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one write cycle; when the task returns, the register is updated
  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    regSel = 1'b1; wrEn = 1'b1; wrData = d;
    @(negedge clk);
    regSel = 1'b0; wrEn = 1'b0; wrData = 8'h00;
  endtask

  task automatic chkOut(input string req, input logic [7:0] rd, input logic en,
                        input logic rs, input logic ar);
    #1;
    chk(req, rdData, rd);
    chk(req, {7'b0, rewriteEn}, {7'b0, en});
    chk(req, {7'b0, ctlReset}, {7'b0, rs});
    chk(req, {7'b0, bootAreaSel}, {7'b0, ar});
  endtask

  task automatic t_reset;
    chkOut("R1", 8'h01, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_ready;
    engineBusy = 1'b1; #1 chk("R2", rdData, 8'h00);
    engineBusy = 1'b0; #1 chk("R2", rdData, 8'h01);
  endtask

  task automatic t_unarmed;
    progVoltOk = 1'b1;
    wr(8'h0A);
    chkOut("R4", 8'h01, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_arm;
    wr(8'h00);
    repeat (3) @(negedge clk);
    wr(8'h02);
    chkOut("R3", 8'h07, 1'b1, 1'b0, 1'b0);
    progVoltOk = 1'b0;
    chkOut("R5", 8'h03, 1'b0, 1'b0, 1'b0);
    progVoltOk = 1'b1;
    chkOut("R5", 8'h07, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_ctlReset;
    wr(8'h00);
    wr(8'h08);
    chkOut("R7", 8'h09, 1'b0, 1'b0, 1'b0);
    wr(8'h0A);
    chkOut("R6", 8'h0F, 1'b1, 1'b1, 1'b0);
    wr(8'h02);
    chkOut("R6", 8'h07, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_area;
    wr(8'h12);
    chkOut("R8", 8'h17, 1'b1, 1'b0, 1'b1);
    wr(8'h02);
    chkOut("R8", 8'h07, 1'b1, 1'b0, 1'b0);
    bootMode = 1'b1;
    chkOut("R8", 8'h17, 1'b1, 1'b0, 1'b1);
    bootMode = 1'b0;
  endtask

  task automatic t_ignored;
    wr(8'hE7);
    chkOut("R9", 8'h07, 1'b1, 1'b0, 1'b0);
    progVoltOk = 1'b0;
    chkOut("R9", 8'h03, 1'b0, 1'b0, 1'b0);
    progVoltOk = 1'b1;
    wr(8'h00);
    chkOut("R3", 8'h01, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin : watchdog
    #500000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_ready();
    t_unarmed();
    t_arm();
    t_ctlReset();
    t_area();
    t_ignored();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule